// File: doc/BRIEF.md
# Fixed-Coefficient Residue FIR Lane

This block computes one residue channel of a lowpass FIR filter whose arithmetic is done in a residue number system. All arithmetic in the channel is modulo a single modulus that is fixed when the design is elaborated. Input samples arrive as 5-bit residues qualified by a valid strobe. Each accepted sample enters a tap delay line. Every tap is scaled by its own integer coefficient. That scaling is not done by a multiplier: each tap has a constant lookup table holding `(c·r) mod m` for every residue `r`. The products are then reduced by a pipelined tree of modular adders, and each adder does one compare and at most one subtraction.

The coefficient set is given as its first half, and the second half is the mirror image of the first. This makes the impulse response symmetric, so the filter has linear phase. The default set is a 128-tap lowpass whose real-valued coefficients were multiplied by 1024 and rounded to integers. Conversion into and out of the residue domain, and the combining of several channels, belong to the blocks around this one.

Top module: `rns_fir_lane`

## Requirements
- R1: When `out_vld` is high, `out_res` equals `(Σ_k c_k · x[n-k]) mod MODULUS`. Here `x[n]` is the newest accepted input, `x[n-k]` is the input accepted k samples earlier (0 before any input), and `c_k` is the integer coefficient of tap k.
- R2: `out_vld` is high exactly `clog2(NTAPS)+1` clock cycles after a cycle in which `in_vld` was sampled high, and is low otherwise. The default latency is 8 cycles.
- R3: The delay line advances only on cycles where `in_vld` is high. After a run of idle cycles longer than the latency, `out_res` holds the value of the last valid result.
- R4: A negative coefficient acts as its non-negative equivalent in [0, MODULUS-1]. For example, -3 with modulus 7 acts as 4.
- R5: An input code of MODULUS or above, in bits [4:0] of `in_res`, contributes 0 to every tap product.
- R6: While `rst` is high, on every clock edge `out_vld` is 0, `out_res` is 0 and all delay-line and adder stages are cleared. The first results after reset therefore see an all-zero history.
- R7: `out_res` is always in [0, MODULUS-1], including for all-maximum inputs.
- R8: The coefficient of tap k equals `HALF_COEF[k]` for k < NTAPS/2, and `HALF_COEF[NTAPS-1-k]` otherwise. A single input of 1 therefore produces the symmetric sequence `c_k mod MODULUS`, for k = 0 to NTAPS-1.
- R9: The default configuration has 128 taps, modulus 31, and the 64-entry scaled lowpass half-set `LPF_HALF` from the package. Residues are 5-bit unsigned binary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input residue is valid and is shifted into the delay line |
| in_res | input | 5 | Input residue |
| out_vld | output | 1 | Output residue is valid |
| out_res | output | 5 | Filtered output residue |

## Verification
The bench builds two copies of the block. The first uses the default parameters: 128 taps, modulus 31 and the lowpass half-set. Its impulse response walks through all 128 symmetric coefficients and checks the seven-level adder tree with its 8-cycle latency. The second copy has 8 taps, modulus 7 and the half-set {-3, 5, 0, 9}. This brings within reach a negative coefficient, a coefficient larger than the modulus, a short 4-cycle latency, and a wide band of illegal input codes (7 to 31) for the zero-product rule.

// File: rtl/rns_lane_pkg.sv
`timescale 1ns/1ps
package rns_lane_pkg;

    localparam int RES_W     = 5;
    localparam int SUM_W     = RES_W + 1;
    localparam int LUT_DEPTH = 1 << RES_W;

    typedef logic [RES_W-1:0] residue_t;
    typedef logic [LUT_DEPTH-1:0][RES_W-1:0] lut_t;

    // input sample carried through the lane entry
    typedef struct packed {
        logic     vld;
        residue_t res;
    } sample_t;

    // default lowpass: first half of a symmetric 128-tap set, scaled by 1024
    localparam int LPF_TAPS = 128;
    localparam int LPF_HALF [LPF_TAPS/2] = '{
          0,   0,   0,   0,   0,   0,  -1,  -1,   0,   0,
          1,   1,   1,   0,   0,  -1,  -1,  -1,  -1,   1,
          2,   2,   2,   1,  -1,  -3,  -4,  -3,  -1,   1,
          4,   5,   5,   2,  -2,  -6,  -8,  -7,  -3,   3,
          8,  11,   9,   4,  -4, -12, -16, -14,  -6,   6,
         18,  24,  21,   9, -10, -30, -42, -40, -18,  22,
         75, 130, 175, 201
    };

    // non-negative representative of a signed coefficient
    function automatic int reduce_coef(int h, int m);
        int r;
        r = h % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

    // constant product table, evaluated during elaboration only
    function automatic lut_t build_lut(int coef, int m);
        lut_t t;
        int   c;
        t = '0;
        c = reduce_coef(coef, m);
        for (int r = 0; r < LUT_DEPTH; r++) begin
            t[r] = (r < m) ? residue_t'((c * r) % m) : '0;
        end
        return t;
    endfunction

    // one compare, at most one subtract; m is always a constant
    function automatic residue_t mod_add(residue_t a, residue_t b, int m);
        logic [SUM_W-1:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= SUM_W'(m)) s = s - SUM_W'(m);
        return s[RES_W-1:0];
    endfunction

endpackage

// File: rtl/rns_tap_line.sv
`timescale 1ns/1ps
module rns_tap_line
    import rns_lane_pkg::*;
#(
    parameter int NTAPS = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  sample_t                      din,
    output logic [NTAPS-1:0][RES_W-1:0]  taps
);

    logic [NTAPS-1:0][RES_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q[0] <= '0;
        end else if (din.vld) begin
            line_q[0] <= din.res;
        end
    end

    for (genvar k = 1; k < NTAPS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[k] <= '0;
            end else if (din.vld) begin
                line_q[k] <= line_q[k-1];
            end
        end
    end

    assign taps = line_q;

endmodule

// File: rtl/rns_const_mul.sv
`timescale 1ns/1ps
module rns_const_mul
    import rns_lane_pkg::*;
#(
    parameter int MODULUS = 31,
    parameter int COEF    = 0
) (
    input  residue_t r,
    output residue_t p
);

    localparam lut_t TABLE = build_lut(COEF, MODULUS);

    assign p = TABLE[r];

endmodule

// File: rtl/rns_add_tree.sv
`timescale 1ns/1ps
module rns_add_tree
    import rns_lane_pkg::*;
#(
    parameter int MODULUS = 31,
    parameter int NLEAF   = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NLEAF-1:0][RES_W-1:0]  leaf_in,
    output residue_t                     sum
);

    localparam int LEVELS = $clog2(NLEAF);
    localparam int PADDED = 1 << LEVELS;
    localparam int NODES  = PADDED - 1;

    residue_t leaf   [PADDED];
    residue_t node_q [NODES];

    for (genvar i = 0; i < PADDED; i++) begin : g_leaf
        if (i < NLEAF) begin : g_real
            assign leaf[i] = leaf_in[i];
        end else begin : g_pad
            assign leaf[i] = '0;
        end
    end

    // heap layout: node n has children 2n+1 and 2n+2; indices >= NODES are leaves
    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int LC = 2 * n + 1;
        localparam int RC = 2 * n + 2;
        residue_t op_a;
        residue_t op_b;

        if (LC >= NODES) begin : g_la
            assign op_a = leaf[LC - NODES];
        end else begin : g_na
            assign op_a = node_q[LC];
        end

        if (RC >= NODES) begin : g_lb
            assign op_b = leaf[RC - NODES];
        end else begin : g_nb
            assign op_b = node_q[RC];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                node_q[n] <= '0;
            end else begin
                node_q[n] <= mod_add(op_a, op_b, MODULUS);
            end
        end
    end

    assign sum = node_q[0];

endmodule

// File: rtl/rns_fir_lane.sv
`timescale 1ns/1ps
module rns_fir_lane
    import rns_lane_pkg::*;
#(
    parameter int MODULUS              = 31,
    parameter int NTAPS                = LPF_TAPS,
    parameter int HALF_COEF [NTAPS/2]  = LPF_HALF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [4:0] in_res,
    output logic       out_vld,
    output logic [4:0] out_res
);

    localparam int HALF    = NTAPS / 2;
    localparam int LEVELS  = $clog2(NTAPS);
    localparam int LATENCY = LEVELS + 1;

    sample_t                     in_s;
    logic [NTAPS-1:0][RES_W-1:0] taps;
    logic [NTAPS-1:0][RES_W-1:0] prod;
    residue_t                    tree_sum;
    logic [LATENCY-1:0]          vld_q;

    assign in_s = '{vld: in_vld, res: in_res};

    rns_tap_line #(
        .NTAPS (NTAPS)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .din  (in_s),
        .taps (taps)
    );

    // mirrored coefficient selection gives the symmetric response
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        localparam int SRC = (k < HALF) ? k : (NTAPS - 1 - k);
        rns_const_mul #(
            .MODULUS (MODULUS),
            .COEF    (HALF_COEF[SRC])
        ) u_mul (
            .r (taps[k]),
            .p (prod[k])
        );
    end

    rns_add_tree #(
        .MODULUS (MODULUS),
        .NLEAF   (NTAPS)
    ) u_tree (
        .clk     (clk),
        .rst     (rst),
        .leaf_in (prod),
        .sum     (tree_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q <= {vld_q[LATENCY-2:0], in_vld};
        end
    end

    assign out_vld = vld_q[LATENCY-1];
    assign out_res = tree_sum;

endmodule

// File: rtl/rns_fir_lane_chk.sv
`timescale 1ns/1ps
module rns_fir_lane_chk #(
    parameter int MODULUS = 31,
    parameter int LATENCY = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       in_vld,
    input logic       out_vld,
    input logic [4:0] out_res
);

    int since_rst;
    int idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            idle_cnt  <= 0;
        end else begin
            if (since_rst < LATENCY) since_rst <= since_rst + 1;
            if (in_vld)                   idle_cnt <= 0;
            else if (idle_cnt <= LATENCY) idle_cnt <= idle_cnt + 1;
        end
    end

    // R7: residue never leaves [0, MODULUS-1]
    a_r7_out_in_range: assert property (@(posedge clk) disable iff (rst)
        out_res < 5'(MODULUS));

    // R2: valid strobe is the input strobe delayed by the latency
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= LATENCY) |-> (out_vld == $past(in_vld, LATENCY)));

    // R6: reset clears the output side
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_vld && out_res == 5'd0));

    // R3: with no accepted input the settled result holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt > LATENCY) |-> $stable(out_res));

endmodule

bind rns_fir_lane rns_fir_lane_chk #(
    .MODULUS (MODULUS),
    .LATENCY (LATENCY)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_res (out_res)
);

// File: tb/rns_fir_lane_bench.sv
`timescale 1ns/1ps
module rns_fir_lane_bench;
    import rns_lane_pkg::*;

    localparam int BIG_M   = 31;
    localparam int BIG_N   = 128;
    localparam int SM_M    = 7;
    localparam int SM_N    = 8;
    localparam int SM_HALF [SM_N/2] = '{-3, 5, 0, 9};
    localparam int BIG_LAT = 8;   // clog2(128)+1
    localparam int SM_LAT  = 4;   // clog2(8)+1
    localparam int QD      = 4096;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [4:0] big_res = '0, sm_res = '0;
    logic       big_ovld, sm_ovld;
    logic [4:0] big_ores, sm_ores;

    rns_fir_lane #(.MODULUS(BIG_M)) u_rns_fir_lane (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_res(big_res),
        .out_vld(big_ovld), .out_res(big_ores));

    rns_fir_lane #(.MODULUS(SM_M), .NTAPS(SM_N), .HALF_COEF(SM_HALF)) u_rns_fir_lane_small (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_res(sm_res),
        .out_vld(sm_ovld), .out_res(sm_ores));

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    bit checking = 0;
    bit done = 0;
    string tag = "R6";

    int big_hist [BIG_N];
    int sm_hist  [SM_N];
    int big_exp [QD], big_when [QD], sm_exp [QD], sm_when [QD];
    int big_wr = 0, big_rd = 0, sm_wr = 0, sm_rd = 0;
    int big_last = 0, sm_last = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string t, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", t, what, got, exp);
        end
    endtask

    function automatic int big_coef(int k);
        return LPF_HALF[(k < BIG_N/2) ? k : BIG_N-1-k];
    endfunction

    function automatic int sm_coef(int k);
        return SM_HALF[(k < SM_N/2) ? k : SM_N-1-k];
    endfunction

    // plain integer FIR, reduced at the end; illegal codes count as 0
    function automatic int big_ref();
        longint acc = 0;
        for (int k = 0; k < BIG_N; k++) begin
            int x = (big_hist[k] >= BIG_M) ? 0 : big_hist[k];
            acc += longint'(big_coef(k)) * x;
        end
        return int'(((acc % BIG_M) + BIG_M) % BIG_M);
    endfunction

    function automatic int sm_ref();
        longint acc = 0;
        for (int k = 0; k < SM_N; k++) begin
            int x = (sm_hist[k] >= SM_M) ? 0 : sm_hist[k];
            acc += longint'(sm_coef(k)) * x;
        end
        return int'(((acc % SM_M) + SM_M) % SM_M);
    endfunction

    task automatic clear_model();
        for (int k = 0; k < BIG_N; k++) big_hist[k] = 0;
        for (int k = 0; k < SM_N; k++)  sm_hist[k] = 0;
        big_rd = big_wr;
        sm_rd  = sm_wr;
        big_last = 0;
        sm_last  = 0;
    endtask

    task automatic push(bit v, int xb, int xs);
        @(posedge clk); #1;
        in_vld  = v;
        big_res = xb[4:0];
        sm_res  = xs[4:0];
        if (v) begin
            for (int k = BIG_N-1; k > 0; k--) big_hist[k] = big_hist[k-1];
            big_hist[0] = xb;
            for (int k = SM_N-1; k > 0; k--) sm_hist[k] = sm_hist[k-1];
            sm_hist[0] = xs;
            big_last = big_ref();
            sm_last  = sm_ref();
            big_exp[big_wr % QD] = big_last; big_when[big_wr % QD] = cyc + BIG_LAT; big_wr++;
            sm_exp[sm_wr % QD]   = sm_last;  sm_when[sm_wr % QD]   = cyc + SM_LAT;  sm_wr++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) push(1'b0, 0, 0);
    endtask

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst && checking) begin
            if (big_rd < big_wr && big_when[big_rd % QD] == cyc) begin
                check("R2", "big out_vld", int'(big_ovld), 1);
                check(tag, "big out_res", int'(big_ores), big_exp[big_rd % QD]);
                big_rd++;
            end else if (big_ovld) begin
                check("R2", "big spurious out_vld", 1, 0);
            end
            if (sm_rd < sm_wr && sm_when[sm_rd % QD] == cyc) begin
                check("R2", "small out_vld", int'(sm_ovld), 1);
                check(tag, "small out_res", int'(sm_ores), sm_exp[sm_rd % QD]);
                sm_rd++;
            end else if (sm_ovld) begin
                check("R2", "small spurious out_vld", 1, 0);
            end
            check("R7", "big range", int'(big_ores < 5'(BIG_M)), 1);
            check("R7", "small range", int'(sm_ores < 5'(SM_M)), 1);
        end
    end

    task automatic reset_and_check();
        @(posedge clk); #1;
        rst = 1'b1; in_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6", "big out_vld in reset", int'(big_ovld), 0);
        check("R6", "big out_res in reset", int'(big_ores), 0);
        check("R6", "small out_vld in reset", int'(sm_ovld), 0);
        check("R6", "small out_res in reset", int'(sm_ores), 0);
        clear_model();
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7351));
        clear_model();
        repeat (2) @(posedge clk);
        reset_and_check();
        checking = 1;

        // small-lane impulse: taps -3,5,0,9,9,0,5,-3 -> 4,5,0,2,2,0,5,4 mod 7
        tag = "R4";
        push(1'b1, 0, 1);
        for (int i = 0; i < SM_N + 2; i++) push(1'b1, 0, 0);
        idle(SM_LAT + 2);

        // default-lane impulse walks the whole symmetric set
        tag = "R8/R9";
        push(1'b1, 1, 0);
        for (int i = 0; i < BIG_N + 2; i++) push(1'b1, 0, 0);
        idle(BIG_LAT + 2);

        // random stream with gaps; occasional illegal codes
        tag = "R1";
        for (int i = 0; i < 600; i++) begin
            bit v  = ($urandom % 4) != 0;
            int xb = (($urandom % 10) == 0) ? 31 : int'($urandom % BIG_M);
            int xs = (($urandom % 7) == 0) ? 7 + int'($urandom % 25) : int'($urandom % SM_M);
            push(v, xb, xs);
        end

        // hold after a long idle run
        idle(2 * BIG_LAT + 4);
        @(negedge clk);
        check("R3", "big hold", int'(big_ores), big_last);
        check("R3", "small hold", int'(sm_ores), sm_last);

        // illegal codes only: treated as zero inputs
        tag = "R5";
        for (int i = 0; i < 12; i++) push(1'b1, 31, 7 + i * 2);
        idle(BIG_LAT + 2);

        // all-maximum residues stress the wrap of every adder
        tag = "R7";
        for (int i = 0; i < BIG_N + 10; i++) push(1'b1, BIG_M - 1, SM_M - 1);
        idle(BIG_LAT + 2);

        // reset mid-run, then an impulse must see a clean history
        reset_and_check();
        tag = "R6";
        push(1'b1, 3, 2);
        for (int i = 0; i < SM_N + 4; i++) push(1'b1, 0, 0);
        idle(BIG_LAT + 4);

        checking = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule